// File: doc/BRIEF.md
# Multi-Channel Interval Timer

A peripheral with a parameterised number of independent down-counting timer channels (four by default, each counter 32 bits wide) behind a plain APB slave. Each channel owns a 64-byte register window. Every channel can run periodically, reloading itself at each expiry, or once, stopping itself after the first expiry. All channels advance on a single shared tick enable, so the tick rate sets the time base.

An expiry sets a pending flag for the channel. The flag drives that channel's interrupt line unless the channel's mask bit is set. Software clears the flag by writing the channel's clear register. A status register, visible at offset 0x00 of every window, gathers the raw pending flags of all channels.

Top module: `mc_interval_timer`

## Requirements
- R1: Channel n decodes byte addresses n*0x40 to n*0x40+0x3F. Window offsets: 0x00 status (read-only), 0x04 mode (bit 0, 0 = periodic, 1 = one-shot), 0x08 load value, 0x10 run enable (bit 0), 0x14 reload strobe, 0x18 current count (read-only), 0x20 clear, 0x24 mask (bit 0). Any other offset, and the reload strobe, read as 0.
- R2: A running channel decrements its count by one on each cycle with tick_i high. A stopped channel, or a cycle without a tick, leaves the count unchanged.
- R3: A tick that arrives while a running channel's count is 0 is an expiry. It sets the pending flag. In periodic mode the count then takes the load value, so the period is load+1 ticks.
- R4: In one-shot mode an expiry clears the run enable and the count stays at 0.
- R5: Writing the load register does not change the count. Writing 1 to the run enable while the channel is stopped copies the load value into the count.
- R6: Any write to the reload strobe, whatever the data, copies the load value into the count. This takes precedence over a tick in the same cycle.
- R7: A write to the clear register clears the pending flag. If an expiry happens in the same cycle, the flag stays set.
- R8: The clear register reads bit 1 = 0 in the cycle after a clear write and bit 1 = 1 at all other times. All its other bits read 0.
- R9: irq_o[n] is the pending flag of channel n gated by the inverse of its mask bit. Status bits [NCH-1:0] show the raw pending flags whatever the mask settings.
- R10: After reset, all registers, counts, flags and interrupts are 0.
- R11: pready_o is always 1. prdata_o follows paddr_i combinationally, so it is valid in both the setup and the access phase. Writes take effect on the clock edge that ends the access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Shared count enable |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | AW (8) | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| irq_o | output | NCH (4) | Per-channel interrupt |

## Verification
The hardest case to reach is an expiry that lands on the same edge as a clear write, so that the pending flag survives the clear. The bench reaches it by loading 0 into a periodic channel and driving tick_i high every cycle, which makes every edge an expiry. A clear then cannot avoid the collision. A second case is the one-cycle low of the clear-available bit. It is only visible to a read whose setup phase begins right at the end of the clear write, so the bench issues that read back to back with the write. A reference model steps every channel on every clock and is compared against the interrupt lines each cycle and against every read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned WIN_AW = 6;  // 64-byte window per channel

  typedef enum logic [WIN_AW-1:0] {
    OFF_STAT = 6'h00,
    OFF_MODE = 6'h04,
    OFF_LOAD = 6'h08,
    OFF_EN   = 6'h10,
    OFF_RLD  = 6'h14,
    OFF_VAL  = 6'h18,
    OFF_CLR  = 6'h20,
    OFF_MSK  = 6'h24
  } reg_off_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH),
  localparam int AW  = tmr_pkg::WIN_AW + CHW
) (
  input  logic [AW-1:0]             paddr_i,
  input  logic                      wr_stb_i,
  output logic [NCH-1:0]            wr_ch_o,
  output logic [CHW-1:0]            ch_o,
  output logic [tmr_pkg::WIN_AW-1:0] off_o
);
  assign ch_o  = paddr_i[AW-1:tmr_pkg::WIN_AW];
  assign off_o = paddr_i[tmr_pkg::WIN_AW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign wr_ch_o[g] = wr_stb_i && (ch_o == CHW'(g));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [WIN_AW-1:0] off_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic          mode_q, en_q, pend_q, mask_q, busy_q;
  logic [CW-1:0] load_q, cnt_q;

  logic wr_mode, wr_load, wr_en, wr_rld, wr_clr, wr_msk;
  assign wr_mode = wr_i && (off_i == OFF_MODE);
  assign wr_load = wr_i && (off_i == OFF_LOAD);
  assign wr_en   = wr_i && (off_i == OFF_EN);
  assign wr_rld  = wr_i && (off_i == OFF_RLD);
  assign wr_clr  = wr_i && (off_i == OFF_CLR);
  assign wr_msk  = wr_i && (off_i == OFF_MSK);

  logic expire, start;
  assign expire = en_q && tick_i && (cnt_q == '0);
  assign start  = wr_en && wdata_i[0] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      mask_q <= 1'b0;
      busy_q <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= wr_clr;
      if (wr_mode) mode_q <= wdata_i[0];
      if (wr_load) load_q <= wdata_i;
      if (wr_msk)  mask_q <= wdata_i[0];
      // software restart beats the tick
      if (wr_rld || start)      cnt_q <= load_q;
      else if (en_q && tick_i)  cnt_q <= expire ? (mode_q ? cnt_q : load_q) : cnt_q - 1'b1;
      if (wr_en)                en_q <= wdata_i[0];
      else if (expire && mode_q) en_q <= 1'b0;
      // set wins over clear
      if (expire)      pend_q <= 1'b1;
      else if (wr_clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_MODE: rdata_o[0] = mode_q;
      OFF_LOAD: rdata_o    = load_q;
      OFF_EN:   rdata_o[0] = en_q;
      OFF_VAL:  rdata_o    = cnt_q;
      OFF_CLR:  rdata_o[1] = !busy_q;
      OFF_MSK:  rdata_o[0] = mask_q;
      default:  rdata_o    = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && !mask_q;

  // R2
  count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i && cnt_q != '0 && !wr_rld) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_rld && !start) |=> $stable(cnt_q));
  // R3
  cont_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !mode_q && !wr_rld) |=> (cnt_q == $past(load_q)) && pend_q);
  // R4
  single_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mode_q && !wr_en && !wr_rld) |=> !en_q && (cnt_q == '0));
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !expire) |=> !pend_q);
endmodule

// File: rtl/mc_interval_timer.sv
module mc_interval_timer #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  localparam int CHW = $clog2(NCH),
  localparam int AW  = tmr_pkg::WIN_AW + CHW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [CW-1:0]  pwdata_i,
  output logic [CW-1:0]  prdata_o,
  output logic           pready_o,
  output logic [NCH-1:0] irq_o
);
  import tmr_pkg::*;

  logic [NCH-1:0]    wr_ch, pend;
  logic [CHW-1:0]    ch;
  logic [WIN_AW-1:0] off;
  logic [CW-1:0]     ch_rdata [NCH];

  tmr_addr_dec #(.NCH(NCH)) u_dec (
    .paddr_i (paddr_i),
    .wr_stb_i(psel_i && penable_i && pwrite_i),
    .wr_ch_o (wr_ch),
    .ch_o    (ch),
    .off_o   (off)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_channel #(.CW(CW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .wr_i   (wr_ch[g]),
      .off_i  (off),
      .wdata_i(pwdata_i),
      .rdata_o(ch_rdata[g]),
      .pend_o (pend[g]),
      .irq_o  (irq_o[g])
    );
  end

  always_comb begin
    prdata_o = '0;
    if (off == OFF_STAT)              prdata_o[NCH-1:0] = pend;
    else if (int'(ch) < NCH)          prdata_o = ch_rdata[ch];
  end

  assign pready_o = 1'b1;
endmodule

// File: tb/mc_interval_timer_tb.sv
module mc_interval_timer_tb;
  localparam int P   = 10;
  localparam int NCH = 4;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready;
  logic [3:0]  irq;

  int errors = 0, checks = 0, tick_mode = 0, tcnt = 0;
  bit done = 0;

  mc_interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .irq_o(irq));

  always #(P/2) clk = ~clk;

  // reference model state
  bit          m_mode[NCH], m_en[NCH], m_pend[NCH], m_mask[NCH], m_busy[NCH];
  logic [31:0] m_load[NCH], m_cnt[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = 0; m_en[c] = 0; m_pend[c] = 0; m_mask[c] = 0; m_busy[c] = 0;
        m_load[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit wr, exp_now, n_en, n_pend;
        logic [31:0] n_cnt;
        int off;
        wr = psel && penable && pwrite && (paddr[7:6] == 2'(c));
        off = int'(paddr[5:0]);
        exp_now = m_en[c] && tick && (m_cnt[c] == 0);
        n_cnt = m_cnt[c]; n_en = m_en[c]; n_pend = m_pend[c];
        if (m_en[c] && tick) begin
          if (m_cnt[c] == 0) begin
            if (m_mode[c]) n_en = 0; else n_cnt = m_load[c];
          end else n_cnt = m_cnt[c] - 1;
        end
        m_busy[c] = wr && off == 'h20;
        if (wr) begin
          case (off)
            'h04: m_mode[c] = pwdata[0];
            'h10: begin if (pwdata[0] && !m_en[c]) n_cnt = m_load[c]; n_en = pwdata[0]; end
            'h14: n_cnt = m_load[c];
            'h20: n_pend = 0;
            'h24: m_mask[c] = pwdata[0];
            default: ;
          endcase
        end
        if (exp_now) n_pend = 1;
        if (wr && off == 'h08) m_load[c] = pwdata;
        m_cnt[c] = n_cnt; m_en[c] = n_en; m_pend[c] = n_pend;
      end
    end
  end

  function automatic logic [31:0] exp_rd(int c, int off);
    logic [31:0] v = '0;
    case (off)
      'h00: for (int k = 0; k < NCH; k++) v[k] = m_pend[k];
      'h04: v[0] = m_mode[c];
      'h08: v = m_load[c];
      'h10: v[0] = m_en[c];
      'h18: v = m_cnt[c];
      'h20: v[1] = !m_busy[c];
      'h24: v[0] = m_mask[c];
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tick pattern
  always @(negedge clk) begin
    tcnt++;
    tick = (tick_mode == 1) || (tick_mode == 2 && tcnt % 3 == 0);
  end

  // every-cycle comparison of interrupt lines (R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e;
      for (int c = 0; c < NCH; c++) e[c] = m_pend[c] && !m_mask[c];
      chk(32'(irq), 32'(e), "R9 irq per cycle");
    end
  end

  // called at a negedge, returns at a negedge after the write edge
  task automatic wr(int c, int off, logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = 8'(c * 64 + off); pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // samples in setup phase and checks against the model
  task automatic rd(int c, int off, string tag, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = 8'(c * 64 + off);
    #(P/4); d = prdata;
    chk(d, exp_rd(c, off), tag);
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd(0, 'h18, "R10 count", d);    chk(d, 0, "R10 count zero");
    rd(2, 'h20, "R10 clr", d);      chk(d, 2, "R10 clear avail");
    rd(1, 'h00, "R10 status", d);   chk(d, 0, "R10 status zero");
    chk(32'(pready), 1, "R11 pready");
    // R5 load alone leaves count
    wr(0, 'h08, 5);
    rd(0, 'h18, "R5 count", d);     chk(d, 0, "R5 load no effect");
    rd(0, 'h08, "R1 load", d);      chk(d, 5, "R1 load readback");
    wr(0, 'h10, 1);
    rd(0, 'h18, "R5 start", d);     chk(d, 5, "R5 start copies load");
    // R2 counting
    tick_mode = 1; repeat (2) @(negedge clk); tick_mode = 0; @(negedge clk);
    rd(0, 'h18, "R2 count down", d);
    tick_mode = 2; repeat (40) @(negedge clk); tick_mode = 0; @(negedge clk);
    rd(0, 'h18, "R3 periodic count", d);
    rd(0, 'h00, "R3 status", d);    chk(d & 1, 1, "R3 pending set");
    // R9 mask
    wr(0, 'h24, 1);
    chk(32'(irq[0]), 0, "R9 masked irq");
    rd(3, 'h00, "R9 raw status", d); chk(d & 1, 1, "R9 raw pending via ch3 window");
    // R7/R8 clear
    wr(0, 'h20, 0);
    rd(0, 'h20, "R8 busy", d);      chk(d, 0, "R8 avail low after clear");
    rd(0, 'h20, "R8 avail", d);     chk(d, 2, "R8 avail back");
    rd(0, 'h00, "R7 cleared", d);   chk(d & 1, 0, "R7 pending cleared");
    wr(0, 'h24, 0);
    // R4 one-shot
    wr(1, 'h04, 1); wr(1, 'h08, 2); wr(1, 'h10, 1);
    tick_mode = 1; repeat (10) @(negedge clk); tick_mode = 0; @(negedge clk);
    rd(1, 'h10, "R4 enable", d);    chk(d, 0, "R4 enable cleared");
    rd(1, 'h18, "R4 count", d);     chk(d, 0, "R4 count held at 0");
    chk(32'(irq[1]), 1, "R4 irq raised");
    // R6 reload with any data
    wr(1, 'h14, 0);
    rd(1, 'h18, "R6 reload 0", d);  chk(d, 2, "R6 reload data 0");
    wr(1, 'h08, 7); wr(1, 'h14, 1);
    rd(1, 'h18, "R6 reload 1", d);  chk(d, 7, "R6 reload data 1");
    rd(1, 'h14, "R1 strobe reads 0", d); chk(d, 0, "R1 strobe read zero");
    tick_mode = 1; repeat (2) @(negedge clk);
    wr(0, 'h14, 32'hFFFF);
    rd(0, 'h18, "R6 precedence", d); chk(d, 5, "R6 reload over tick");
    // R7 clear colliding with expiry
    wr(2, 'h10, 1);
    repeat (3) @(negedge clk);
    wr(2, 'h20, 0);
    rd(2, 'h00, "R7 collision", d); chk(d & 4, 4, "R7 set wins");
    tick_mode = 0; repeat (2) @(negedge clk);
    wr(2, 'h20, 0);
    rd(2, 'h00, "R7 clear", d);     chk(d & 4, 0, "R7 clear after ticks stop");
    // R2 stopped channel holds
    wr(3, 'h08, 9); wr(3, 'h14, 0);
    tick_mode = 1; repeat (5) @(negedge clk); tick_mode = 0; @(negedge clk);
    rd(3, 'h18, "R2 hold", d);      chk(d, 9, "R2 stopped holds");
    // R1 unmapped offset
    rd(3, 'h0C, "R1 unmapped", d);  chk(d, 0, "R1 unmapped zero");
    rd(2, 'h24, "R1 mask ch2", d);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule